// File: doc/BRIEF.md
# Two-Rate Three-Colour Packet Meter

This block meters a stream of received packets against two token buckets, a committed bucket and a peak bucket. It returns a colour (green, yellow or red) and a 2-bit action code for every packet. Refill rates and bucket capacities are coded as a scaled power of two, (1 + M/256)·2^E tokens. Refill happens once every 2^rdiv pulses of an external 2 µs strobe. An exponent of 24 or more switches a bucket off, so that bucket neither fills nor holds tokens.

Token counts are fixed point with 8 fractional bits. The cost of one packet is its length less a configurable offset, plus a signed adjust term (ADJ_M/256 − 1)·2^ADJ_E, and never less than 1/256 token. A length-mode bit drops the length part of the cost. With that bit set, ADJ_M = 384 and ADJ_E = 1, every packet costs exactly one token, so the same logic meters packets per second instead of bytes. Software writes six configuration words through a simple write port. The result appears one cycle after the request.

Top module: `tm_meter`

## Requirements
- R1: Configuration words sit at these `cfg_addr` values: 0 committed rate, 1 committed size, 2 peak rate, 3 peak size, 4 cost, 5 mode. Each of words 0–3 holds M in bits [7:0] and E in bits [12:8]. The cost word holds ADJ_M in [8:0], ADJ_E in [13:9], the length-mode bit in [14] and the length offset in [30:15]. The mode word holds rdiv in [3:0], the input-colour mode in [5:4], the algorithm in [7:6], the green action in [9:8], the yellow action in [11:10] and the red action in [13:12]. After reset every bucket has E = 24 and M = 0, ADJ_M = 256, ADJ_E = 0, the length mode and offset are 0, rdiv = 0, the colour mode is 3, the algorithm is 2, the green and yellow actions are 0 and the red action is 1. Writing a size word fills that bucket to its new capacity.
- R2: Each refill adds (1 + M/256)·2^E tokens from the matching rate word to a bucket. A refill takes place on every 2^rdiv-th cycle in which `tick_2us` is high. Writing the mode word restarts this count.
- R3: A bucket saturates at its capacity, (1 + M/256)·2^E tokens from its size word.
- R4: An exponent of 24 or more gives a rate or capacity of zero, which disables that bucket. With the peak bucket disabled, no packet is coloured yellow.
- R5: With length mode 0, a packet costs (length − offset) + (ADJ_M − 256)·2^ADJ_E/256 tokens, and at least 1/256 token.
- R6: With length mode 1, the length takes no part in the cost. With ADJ_M = 384 and ADJ_E = 1, each packet costs one token.
- R7: With algorithm 2, a packet is green (`res_color` 0) and debits the committed bucket when that bucket holds at least its cost. Otherwise it is yellow (1) and debits the peak bucket when the peak bucket covers the cost. Otherwise it is red (2) and no bucket changes.
- R8: Colour mode 3 ignores `pkt_color`. Any other mode honours it (0 green, 1 yellow, 2 or 3 red): a red input stays red and debits nothing, and a yellow input cannot become green.
- R9: `res_action` is the action field that the mode word holds for the colour produced.
- R10: With any algorithm code other than 2, every packet is green and no bucket is debited.
- R11: `res_valid` is high in the cycle after `pkt_valid` and low otherwise, and `res_color` and `res_action` are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (3) | Configuration word select |
| cfg_wdata | input | DW (32) | Configuration write data |
| tick_2us | input | 1 | Timebase strobe, one cycle every 2 µs |
| pkt_valid | input | 1 | Packet metering request |
| pkt_len | input | LEN_W (16) | Packet length in bytes |
| pkt_color | input | 2 | Pre-colour of the packet |
| res_valid | output | 1 | Result valid |
| res_color | output | 2 | 0 green, 1 yellow, 2 red |
| res_action | output | 2 | Action code for the colour produced |

## Verification
The bench builds the meter with its default parameters: 16-bit lengths, 34-bit token counters and a 4-bit rdiv, which gives a prescaler up to 2^15 strobes. At these widths, exponents up to 23 fit with no overflow. The bench uses small buckets (2 to 2048 tokens) so that exact-fit and one-token-short cases land on known boundaries. It uses rdiv = 2 to show the prescaler count, and a run of 100 refills to drive the committed bucket into saturation. The fixed-point cost path is exercised with a length offset, a negative adjust term, a zero-length cost floored to 1/256, and the one-token-per-packet setting.

// File: rtl/tm_pkg.sv
package tm_pkg;
  typedef enum logic [1:0] {
    COL_GREEN  = 2'd0,
    COL_YELLOW = 2'd1,
    COL_RED    = 2'd2
  } color_e;

  localparam int ADDR_CRATE  = 0;
  localparam int ADDR_CSIZE  = 1;
  localparam int ADDR_PRATE  = 2;
  localparam int ADDR_PSIZE  = 3;
  localparam int ADDR_COST   = 4;
  localparam int ADDR_MODE   = 5;

  localparam logic [4:0] EXP_OFF     = 5'd24;
  localparam logic [1:0] ALGO_TRTCM  = 2'd2;
  localparam logic [1:0] ICOL_BLIND  = 2'd3;

  typedef struct packed {
    logic [4:0] e;
    logic [7:0] m;
  } mexp_t;
endpackage

// File: rtl/tm_cfg_regs.sv
module tm_cfg_regs
  import tm_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter int LEN_W  = 16,
  parameter int TOK_W  = 34,
  parameter int RDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [TOK_W-1:0]  rate_c,
  output logic [TOK_W-1:0]  cap_c,
  output logic [TOK_W-1:0]  rate_p,
  output logic [TOK_W-1:0]  cap_p,
  output logic              ld_c,
  output logic              ld_p,
  output logic [8:0]        adj_m,
  output logic [4:0]        adj_e,
  output logic              lmode,
  output logic [LEN_W-1:0]  lxoff,
  output logic [RDIV_W-1:0] rdiv,
  output logic [1:0]        icolor,
  output logic [1:0]        algo,
  output logic [1:0]        act_g,
  output logic [1:0]        act_y,
  output logic [1:0]        act_r,
  output logic              pre_clr
);
  localparam int NBK     = 4;
  localparam int OFF_LSB = 15;

  mexp_t bk [NBK];
  logic [TOK_W-1:0] bk_val [NBK];

  function automatic logic [TOK_W-1:0] decode(input mexp_t v);
    logic [TOK_W-1:0] base;
    base = TOK_W'({1'b1, v.m});
    if (v.e >= EXP_OFF) return '0;
    return base << v.e;
  endfunction

  for (genvar gi = 0; gi < NBK; gi++) begin : g_bk
    always_ff @(posedge clk) begin
      if (rst) begin
        bk[gi] <= '{e: EXP_OFF, m: 8'd0};
      end else if (we && addr == AW'(gi)) begin
        bk[gi] <= '{e: wdata[12:8], m: wdata[7:0]};
      end
    end
    assign bk_val[gi] = decode(bk[gi]);
  end

  assign rate_c = bk_val[ADDR_CRATE];
  assign cap_c  = bk_val[ADDR_CSIZE];
  assign rate_p = bk_val[ADDR_PRATE];
  assign cap_p  = bk_val[ADDR_PSIZE];

  always_ff @(posedge clk) begin
    if (rst) begin
      adj_m   <= 9'd256;
      adj_e   <= 5'd0;
      lmode   <= 1'b0;
      lxoff   <= '0;
      rdiv    <= '0;
      icolor  <= ICOL_BLIND;
      algo    <= ALGO_TRTCM;
      act_g   <= 2'd0;
      act_y   <= 2'd0;
      act_r   <= 2'd1;
      ld_c    <= 1'b0;
      ld_p    <= 1'b0;
      pre_clr <= 1'b0;
    end else begin
      ld_c    <= we && addr == AW'(ADDR_CSIZE);
      ld_p    <= we && addr == AW'(ADDR_PSIZE);
      pre_clr <= we && addr == AW'(ADDR_MODE);
      if (we && addr == AW'(ADDR_COST)) begin
        adj_m <= wdata[8:0];
        adj_e <= wdata[13:9];
        lmode <= wdata[14];
        lxoff <= wdata[OFF_LSB +: LEN_W];
      end
      if (we && addr == AW'(ADDR_MODE)) begin
        rdiv   <= wdata[RDIV_W-1:0];
        icolor <= wdata[5:4];
        algo   <= wdata[7:6];
        act_g  <= wdata[9:8];
        act_y  <= wdata[11:10];
        act_r  <= wdata[13:12];
      end
    end
  end
endmodule

// File: rtl/tm_prescaler.sv
module tm_prescaler #(
  parameter int RDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  logic [RDIV_W-1:0] rdiv,
  output logic              refill
);
  localparam int CNT_W = 1 << RDIV_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit  = (CNT_W'(1) << rdiv) - CNT_W'(1);
  assign refill = tick && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= refill ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tm_cost.sv
module tm_cost #(
  parameter int LEN_W = 16,
  parameter int TOK_W = 34
) (
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] lxoff,
  input  logic             lmode,
  input  logic [8:0]       adj_m,
  input  logic [4:0]       adj_e,
  output logic [TOK_W-1:0] cost
);
  localparam int CW    = TOK_W + 2;
  localparam int FRAC  = 8;
  localparam int E_MAX = 23;

  logic signed [CW-1:0] len_term;
  logic signed [CW-1:0] adj_term;
  logic signed [CW-1:0] sum;
  logic signed [9:0]    adj_d;
  logic [4:0]           e_cl;

  always_comb begin
    e_cl  = (adj_e > 5'(E_MAX)) ? 5'(E_MAX) : adj_e;
    adj_d = $signed({1'b0, adj_m}) - 10'sd256;
    adj_term = CW'(adj_d) <<< e_cl;
    if (lmode) begin
      len_term = '0;
    end else begin
      len_term = (CW'($signed({1'b0, len})) - CW'($signed({1'b0, lxoff}))) <<< FRAC;
    end
    sum = len_term + adj_term;
    if (sum <= 0) cost = TOK_W'(1);
    else          cost = sum[TOK_W-1:0];
  end
endmodule

// File: rtl/tm_bucket.sv
module tm_bucket #(
  parameter int TOK_W = 34
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TOK_W-1:0] cap,
  input  logic [TOK_W-1:0] rate,
  input  logic             refill,
  input  logic             debit,
  input  logic [TOK_W-1:0] cost,
  output logic [TOK_W-1:0] level
);
  logic [TOK_W:0] after_deb;
  logic [TOK_W:0] nxt;

  always_comb begin
    after_deb = {1'b0, level} - (debit ? {1'b0, cost} : '0);
    nxt       = after_deb + (refill ? {1'b0, rate} : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (load) begin
      level <= cap;
    end else if (nxt > {1'b0, cap}) begin
      level <= cap;
    end else begin
      level <= nxt[TOK_W-1:0];
    end
  end
endmodule

// File: rtl/tm_meter.sv
module tm_meter
  import tm_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter int LEN_W  = 16,
  parameter int TOK_W  = 34,
  parameter int RDIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             tick_2us,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [1:0]       pkt_color,
  output logic             res_valid,
  output logic [1:0]       res_color,
  output logic [1:0]       res_action
);
  localparam int NB = 2;

  logic [TOK_W-1:0]  rate_c, cap_c, rate_p, cap_p;
  logic              ld_c, ld_p, lmode, pre_clr, refill;
  logic [8:0]        adj_m;
  logic [4:0]        adj_e;
  logic [LEN_W-1:0]  lxoff;
  logic [RDIV_W-1:0] rdiv;
  logic [1:0]        icolor, algo, act_g, act_y, act_r;
  logic [TOK_W-1:0]  cost;
  logic [TOK_W-1:0]  lvl_c, lvl_p;
  logic              deb_c, deb_p, aware;
  color_e            col;
  logic [1:0]        act;

  logic [TOK_W-1:0] b_rate [NB];
  logic [TOK_W-1:0] b_cap  [NB];
  logic [TOK_W-1:0] b_lvl  [NB];
  logic             b_ld   [NB];
  logic             b_deb  [NB];

  tm_cfg_regs #(.DW(DW), .AW(AW), .LEN_W(LEN_W), .TOK_W(TOK_W), .RDIV_W(RDIV_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rate_c(rate_c), .cap_c(cap_c), .rate_p(rate_p), .cap_p(cap_p),
    .ld_c(ld_c), .ld_p(ld_p), .adj_m(adj_m), .adj_e(adj_e), .lmode(lmode),
    .lxoff(lxoff), .rdiv(rdiv), .icolor(icolor), .algo(algo),
    .act_g(act_g), .act_y(act_y), .act_r(act_r), .pre_clr(pre_clr)
  );

  tm_prescaler #(.RDIV_W(RDIV_W)) u_pre (
    .clk(clk), .rst(rst), .clr(pre_clr), .tick(tick_2us), .rdiv(rdiv), .refill(refill)
  );

  tm_cost #(.LEN_W(LEN_W), .TOK_W(TOK_W)) u_cost (
    .len(pkt_len), .lxoff(lxoff), .lmode(lmode), .adj_m(adj_m), .adj_e(adj_e), .cost(cost)
  );

  assign b_rate[0] = rate_c;
  assign b_cap[0]  = cap_c;
  assign b_ld[0]   = ld_c;
  assign b_deb[0]  = deb_c;
  assign b_rate[1] = rate_p;
  assign b_cap[1]  = cap_p;
  assign b_ld[1]   = ld_p;
  assign b_deb[1]  = deb_p;

  for (genvar gi = 0; gi < NB; gi++) begin : g_bkt
    tm_bucket #(.TOK_W(TOK_W)) u_bkt (
      .clk(clk), .rst(rst), .load(b_ld[gi]), .cap(b_cap[gi]), .rate(b_rate[gi]),
      .refill(refill), .debit(b_deb[gi]), .cost(cost), .level(b_lvl[gi])
    );
  end

  assign lvl_c = b_lvl[0];
  assign lvl_p = b_lvl[1];

  always_comb begin
    aware = (icolor != ICOL_BLIND);
    col   = COL_RED;
    deb_c = 1'b0;
    deb_p = 1'b0;
    if (algo != ALGO_TRTCM) begin
      col = COL_GREEN;
    end else if (aware && pkt_color[1]) begin
      col = COL_RED;
    end else if ((!aware || pkt_color == 2'd0) && lvl_c >= cost) begin
      col   = COL_GREEN;
      deb_c = pkt_valid;
    end else if (lvl_p >= cost) begin
      col   = COL_YELLOW;
      deb_p = pkt_valid;
    end
    case (col)
      COL_GREEN:  act = act_g;
      COL_YELLOW: act = act_y;
      default:    act = act_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_color  <= 2'd0;
      res_action <= 2'd0;
    end else begin
      res_valid <= pkt_valid;
      if (pkt_valid) begin
        res_color  <= col;
        res_action <= act;
      end
    end
  end
endmodule

// File: rtl/tm_meter_chk.sv
module tm_meter_chk #(
  parameter int TOK_W = 34
) (
  input logic             clk,
  input logic             rst,
  input logic             pkt_valid,
  input logic             res_valid,
  input logic [1:0]       res_color,
  input logic [1:0]       res_action,
  input logic [1:0]       act_r,
  input logic [TOK_W-1:0] cap_c,
  input logic [TOK_W-1:0] cap_p,
  input logic [TOK_W-1:0] lvl_c,
  input logic             ld_c,
  input logic             refill
);
  // R11: result valid follows request by one cycle
  a_r11_latency_hi: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> res_valid);
  a_r11_latency_lo: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |=> !res_valid);

  // R3: committed bucket never holds more than its capacity
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !ld_c |-> lvl_c <= cap_c);

  // R4: disabled peak bucket never yields yellow
  a_r4_no_yellow: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(cap_p) == '0) |-> res_color != 2'd1);

  // R9: red result carries the red action field
  a_r9_red_action: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_color == 2'd2) |-> res_action == $past(act_r));

  // R7: red result leaves committed bucket untouched
  a_r7_red_no_debit: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_color == 2'd2 && !$past(refill) && !$past(ld_c))
      |-> lvl_c == $past(lvl_c));
endmodule

bind tm_meter tm_meter_chk #(.TOK_W(TOK_W)) u_chk (
  .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .res_valid(res_valid),
  .res_color(res_color), .res_action(res_action), .act_r(act_r),
  .cap_c(cap_c), .cap_p(cap_p), .lvl_c(lvl_c), .ld_c(ld_c), .refill(refill)
);

// File: tb/tm_meter_tb.sv
module tm_meter_tb;
  localparam int DW = 32, AW = 3, LEN_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic tick_2us = 1'b0;
  logic pkt_valid = 1'b0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic [1:0] pkt_color = '0;
  logic res_valid;
  logic [1:0] res_color, res_action;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [1:0] col;
    logic [1:0] act;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  tm_meter u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tick_2us(tick_2us), .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_color(pkt_color),
    .res_valid(res_valid), .res_color(res_color), .res_action(res_action)
  );

  function automatic logic [DW-1:0] mx(input int m, input int e);
    return DW'(m) | (DW'(e) << 8);
  endfunction
  function automatic logic [DW-1:0] costw(input int am, input int ae, input int lm, input int off);
    return DW'(am) | (DW'(ae) << 9) | (DW'(lm) << 14) | (DW'(off) << 15);
  endfunction
  function automatic logic [DW-1:0] modew(input int rd, input int ic, input int al,
                                          input int g, input int y, input int r);
    return DW'(rd) | (DW'(ic) << 4) | (DW'(al) << 6) | (DW'(g) << 8) | (DW'(y) << 10) | (DW'(r) << 12);
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_2us = 1'b1;
      @(negedge clk); tick_2us = 1'b0;
    end
  endtask

  task automatic pkt(input int len, input int cin, input int ecol, input int eact, input string tag);
    exp_t e;
    e.col = 2'(ecol); e.act = 2'(eact); e.tag = tag;
    @(negedge clk);
    sb.push_back(e);
    pkt_valid = 1'b1; pkt_len = LEN_W'(len); pkt_color = 2'(cin);
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      exp_t e;
      n_tests++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected result: actual col=%0d act=%0d expected none", res_color, res_action);
      end else begin
        e = sb.pop_front();
        if (res_color !== e.col || res_action !== e.act) begin
          n_fail++;
          $display("FAIL %s: actual col=%0d act=%0d expected col=%0d act=%0d",
                   e.tag, res_color, res_action, e.col, e.act);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_tests++;
    if (res_valid !== 1'b0 || res_action !== 2'd0) begin
      n_fail++;
      $display("FAIL R11 reset: actual valid=%0b act=%0d expected valid=0 act=0", res_valid, res_action);
    end

    // R1/R4 defaults: buckets empty and off; red drops with action 1
    pkt(10, 0, 2, 1, "R1 default red");
    // R1 size write fills committed bucket: 1024 tokens
    wr(1, mx(0, 10));
    pkt(1000, 0, 0, 0, "R7 green debit");
    pkt(100, 0, 2, 1, "R7 red short");
    pkt(24, 0, 0, 0, "R7 exact fit");

    // R2 refill 1.5*16=24 tokens every 4 ticks
    wr(0, mx(128, 4));
    wr(5, modew(2, 3, 2, 0, 0, 1));
    ticks(3);
    pkt(1, 0, 2, 1, "R2 before 4th tick");
    ticks(1);
    pkt(24, 0, 0, 0, "R2 after refill");
    pkt(1, 0, 2, 1, "R2 single refill");
    // R3 saturation: 100 refills of 24 capped at 1024
    ticks(400);
    pkt(1024, 0, 0, 0, "R3 full bucket");
    pkt(1, 0, 2, 1, "R3 capped");

    // R8 colour blind vs aware
    wr(1, mx(0, 10));
    pkt(10, 2, 0, 0, "R8 blind ignores red");
    wr(5, modew(0, 0, 2, 0, 0, 1));
    pkt(10, 2, 2, 1, "R8 aware red");
    pkt(10, 1, 2, 1, "R8 aware yellow no green");
    pkt(1014, 0, 0, 0, "R8 no debit on forced colours");

    // R7/R9 peak bucket and yellow action 2
    wr(1, mx(0, 10));
    wr(3, mx(0, 11));
    wr(5, modew(0, 3, 2, 0, 2, 1));
    pkt(1500, 0, 1, 2, "R9 yellow via peak");
    pkt(1000, 0, 0, 0, "R7 green after yellow");
    pkt(600, 0, 2, 1, "R7 neither covers");

    // R6 packet mode: one token per packet, 2-token bucket
    wr(3, mx(0, 24));
    wr(4, costw(384, 1, 1, 0));
    wr(1, mx(0, 1));
    pkt(1500, 0, 0, 0, "R6 first packet");
    pkt(1500, 0, 0, 0, "R6 second packet");
    pkt(1500, 0, 2, 1, "R6 third packet");

    // R5 length offset and 1/256 floor
    wr(4, costw(256, 0, 0, 100));
    wr(1, mx(0, 8));
    pkt(356, 0, 0, 0, "R5 offset cost");
    pkt(100, 0, 2, 1, "R5 floor 1/256");
    // R5 negative adjust: -8 tokens, mantissa bucket 1.5*4=6 tokens
    wr(4, costw(0, 3, 0, 0));
    wr(1, mx(128, 2));
    pkt(14, 0, 0, 0, "R5 neg adjust exact");
    pkt(9, 0, 2, 1, "R5 neg adjust short");

    // R10 other algorithm: green, no debit
    wr(5, modew(0, 3, 0, 0, 0, 1));
    pkt(5000, 0, 0, 0, "R10 bypass");
    pkt(5000, 0, 0, 0, "R10 bypass again");
    wr(5, modew(0, 3, 2, 0, 0, 1));
    pkt(9, 0, 2, 1, "R10 no debit seen");

    repeat (4) @(negedge clk);
    n_tests++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R11 missing results: actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule